// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single output line. The caller offers a word with a valid/ready handshake. When the block accepts the word it takes a snapshot of the configuration inputs. It then drives a low start bit, the data bits, an optional parity bit and a high stop interval. After that it holds the line high for a programmable number of bit times before it will accept another word.

The configuration is applied at run time and covers six settings:
- the bit time, as a divisor in system clocks;
- the data length, from 5 to 8 bits;
- parity: off, even or odd;
- the stop length: 1, 1.5 or 2 bits;
- the bit order: least significant bit first or most significant bit first;
- the inter-frame gap.

Timing is built from half-bit ticks. A 1.5-bit stop is therefore exactly three half-bit ticks.

Top module: `uart_frame_tx`

## Requirements
- R1: While no frame or gap is in progress, and after reset, `tx_line` is 1, `in_ready` is 1 and `busy` is 0.
- R2: An accepted word is sent in this order: one start bit at 0, then the data bits, then the parity bit if enabled, then the stop interval at 1. The line goes low in the first cycle after the accepting edge.
- R3: `cfg_len` selects the number of data bits as 8 minus the code (code 0 gives 8, 1 gives 7, 2 gives 6, 3 gives 5). Word bits above the selected length are not sent and do not enter the parity.
- R4: `cfg_parity` code 1 selects even parity and code 2 selects odd parity; codes 0 and 3 send no parity bit. The parity bit makes the count of ones over the sent data bits plus parity even (code 1) or odd (code 2). For example, 8'h41 gives parity 0 with even parity and 1 with odd parity.
- R5: `cfg_stop` code 0 gives a stop interval of one bit time, code 1 gives 1.5 bit times (three half-bit times), and codes 2 and 3 give two bit times.
- R6: With `cfg_msb_first` at 0 the data go least significant bit first, so 8'h41 with 8 bits is sent as 1,0,0,0,0,0,1,0. With `cfg_msb_first` at 1 the highest selected bit goes first.
- R7: The half-bit time is floor(`cfg_divisor`/2) clocks, with a minimum of 1. A bit time is two half-bit times, so divisors 8 and 9 both give 8 clocks per bit.
- R8: After the stop interval the line stays high for `cfg_gap` bit times while `in_ready` stays 0. `busy` is 1 from the cycle after acceptance through the end of the stop interval, and 0 during the gap.
- R9: `in_ready` is 1 only when idle, and a word is accepted on an edge where `in_valid` and `in_ready` are both 1. The word and all configuration inputs are captured on that edge. Changes to them, and `in_valid` held high during a frame or gap, do not alter the frame in flight.
- R10: Asserting `rst_n` low in the middle of a frame immediately drives `tx_line` to 1, `busy` to 0 and `in_ready` to 1, and the frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_divisor | input | 16 | Bit time in system clocks (the half-bit time is this value shifted right by one) |
| cfg_len | input | 2 | Data length code: number of bits = 8 - code |
| cfg_parity | input | 2 | 0 or 3 = no parity, 1 = even, 2 = odd |
| cfg_stop | input | 2 | 0 = 1 bit, 1 = 1.5 bits, 2 or 3 = 2 bits |
| cfg_msb_first | input | 1 | 1 sends the most significant selected bit first |
| cfg_gap | input | 4 | Idle bit times enforced after each frame |
| in_valid | input | 1 | Word offered |
| in_data | input | 8 | Word to send |
| in_ready | output | 1 | Block is idle and will accept a word |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame (start through stop) in progress |

## Verification
The bench records the line in every clock cycle of each frame and compares it with a waveform it builds itself from the word and the settings. A swapped bit order, a parity that counts the masked upper bits, or a wrong length code therefore shows up as a mismatch at a specific cycle. The stop interval and the gap are measured as counts of cycles during which `busy` and `in_ready` stay low. A 1.5-bit stop rounded to 1 or 2 bits, a gap counted in half bits, or a divisor applied without halving shifts those counts by a known amount. Throughout every frame the bench keeps `in_valid` high and scrambles the word and the settings. A design that fails to capture its inputs on acceptance, or that accepts a word while busy, corrupts the recorded waveform. A reset in the middle of a frame must return the idle outputs at once.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int DIV_W    = 16;
  localparam int GAP_W    = 4;
  localparam int MAX_BITS = 8;
  localparam int CNT_BITS = $clog2(MAX_BITS + 1);
  localparam int IDX_W    = $clog2(MAX_BITS);
  localparam int SEG_W    = GAP_W + 2;

  typedef struct packed {
    logic [DIV_W-1:0] divisor;
    logic [1:0]       len_code;
    logic [1:0]       par_code;
    logic [1:0]       stop_code;
    logic             msb_first;
    logic [GAP_W-1:0] gap;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_GAP
  } tx_state_t;

  // number of data bits sent for a length code
  function automatic logic [CNT_BITS-1:0] data_count(input logic [1:0] code);
    return CNT_BITS'(MAX_BITS - int'(code));
  endfunction

  // half-bit period in clocks, never below one
  function automatic logic [DIV_W-1:0] half_len_of(input logic [DIV_W-1:0] d);
    logic [DIV_W-1:0] h;
    h = d >> 1;
    return (h == '0) ? DIV_W'(1) : h;
  endfunction

  function automatic logic parity_on(input logic [1:0] code);
    return (code == 2'd1) || (code == 2'd2);
  endfunction

  // parity over the first n bits; odd selects odd parity
  function automatic logic parity_of(input logic [MAX_BITS-1:0] w,
                                     input logic [CNT_BITS-1:0] n,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < int'(n)) p = p ^ w[IDX_W'(i)];
    end
    return p;
  endfunction

  // place the bits so that bit 0 always leaves first
  function automatic logic [MAX_BITS-1:0] order_bits(input logic [MAX_BITS-1:0] w,
                                                     input logic [CNT_BITS-1:0] n,
                                                     input logic msb);
    logic [MAX_BITS-1:0] o;
    o = '0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < int'(n)) begin
        if (msb) o[IDX_W'(i)] = w[IDX_W'(int'(n) - 1 - i)];
        else     o[IDX_W'(i)] = w[IDX_W'(i)];
      end
    end
    return o;
  endfunction

  // stop interval length in half-bit ticks
  function automatic logic [SEG_W-1:0] stop_halves(input logic [1:0] code);
    case (code)
      2'd0:    return SEG_W'(2);
      2'd1:    return SEG_W'(3);
      default: return SEG_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/uft_half_tick.sv
module uft_half_tick import uft_pkg::*; #(
  parameter int CNT_W = DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_len,
  output logic             half_tick
);
  logic [CNT_W-1:0] cnt;

  assign half_tick = run && (cnt == half_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (half_tick) cnt <= '0;
    else                cnt <= cnt + CNT_W'(1);
  end

  // R7: the counter never runs past the half-bit period
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half_len));

  // R7: a tick is followed by a counter restart
  a_r7_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && run) |=> (cnt == '0));
endmodule

// File: rtl/uft_serializer.sv
module uft_serializer import uft_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [MAX_BITS-1:0] word,
  input  frame_cfg_t          cfg_in,
  input  logic                half_tick,
  output logic                line,
  output logic                run,
  output logic                in_frame,
  output logic                idle,
  output logic [DIV_W-1:0]    half_len,
  output logic                seg_done
);
  tx_state_t            state;
  frame_cfg_t           cfg_q;
  logic [SEG_W-1:0]     seg_half;
  logic [SEG_W-1:0]     seg_len;
  logic [CNT_BITS-1:0]  bit_idx;
  logic [CNT_BITS-1:0]  nbits;
  logic [MAX_BITS-1:0]  shreg;
  logic                 par_q;
  logic [CNT_BITS-1:0]  in_nbits;

  assign in_nbits = data_count(cfg_in.len_code);
  assign nbits    = data_count(cfg_q.len_code);
  assign half_len = half_len_of(cfg_q.divisor);

  always_comb begin
    case (state)
      ST_STOP: seg_len = stop_halves(cfg_q.stop_code);
      ST_GAP:  seg_len = {cfg_q.gap, 1'b0};
      default: seg_len = SEG_W'(2);
    endcase
  end

  assign seg_done = half_tick && (seg_half == seg_len - SEG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cfg_q    <= '0;
      seg_half <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_q    <= 1'b0;
    end else if (accept && state == ST_IDLE) begin
      cfg_q    <= cfg_in;
      shreg    <= order_bits(word, in_nbits, cfg_in.msb_first);
      par_q    <= parity_of(word, in_nbits, cfg_in.par_code == 2'd2);
      seg_half <= '0;
      bit_idx  <= '0;
      state    <= ST_START;
    end else if (half_tick) begin
      if (!seg_done) begin
        seg_half <= seg_half + SEG_W'(1);
      end else begin
        seg_half <= '0;
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (bit_idx == nbits - CNT_BITS'(1)) begin
              bit_idx <= '0;
              state   <= parity_on(cfg_q.par_code) ? ST_PAR : ST_STOP;
            end else begin
              bit_idx <= bit_idx + CNT_BITS'(1);
            end
          end
          ST_PAR:  state <= ST_STOP;
          ST_STOP: state <= (cfg_q.gap == '0) ? ST_IDLE : ST_GAP;
          ST_GAP:  state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign idle     = (state == ST_IDLE);
  assign run      = !idle;
  assign in_frame = (state != ST_IDLE) && (state != ST_GAP);

  // R9: captured settings hold for the whole frame and gap
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cfg_q));

  // R2: acceptance starts a frame with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && idle) |=> (state == ST_START && !line));

  // R4: a parity slot only occurs when parity is enabled
  a_r4_par_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAR) |-> parity_on(cfg_q.par_code));

  // R3: the bit index stays below the selected data length
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (bit_idx < nbits));

  // R8: the gap state is only entered with a nonzero gap
  a_r8_gap_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (cfg_q.gap != '0));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx import uft_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    cfg_divisor,
  input  logic [1:0]          cfg_len,
  input  logic [1:0]          cfg_parity,
  input  logic [1:0]          cfg_stop,
  input  logic                cfg_msb_first,
  input  logic [GAP_W-1:0]    cfg_gap,
  input  logic                in_valid,
  input  logic [MAX_BITS-1:0] in_data,
  output logic                in_ready,
  output logic                tx_line,
  output logic                busy
);
  frame_cfg_t       cfg_in;
  logic             accept;
  logic             half_tick;
  logic             run;
  logic             in_frame;
  logic             idle;
  logic             seg_done;
  logic [DIV_W-1:0] half_len;

  assign cfg_in = '{divisor:   cfg_divisor,
                    len_code:  cfg_len,
                    par_code:  cfg_parity,
                    stop_code: cfg_stop,
                    msb_first: cfg_msb_first,
                    gap:       cfg_gap};

  assign accept = in_valid && idle;

  uft_half_tick #(.CNT_W(DIV_W)) tick_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .half_len  (half_len),
    .half_tick (half_tick)
  );

  uft_serializer ser_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .word      (in_data),
    .cfg_in    (cfg_in),
    .half_tick (half_tick),
    .line      (tx_line),
    .run       (run),
    .in_frame  (in_frame),
    .idle      (idle),
    .half_len  (half_len),
    .seg_done  (seg_done)
  );

  assign in_ready = idle;
  assign busy     = in_frame;

  // R1: an idle block holds the line high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_line);

  // R8: busy and ready are never both high
  a_r8_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R9: a word offered while not ready leaves the block not ready
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !seg_done) |=> !in_ready);
endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_divisor = 16'd8;
  logic [1:0]  cfg_len = 2'd0;
  logic [1:0]  cfg_parity = 2'd0;
  logic [1:0]  cfg_stop = 2'd0;
  logic        cfg_msb_first = 1'b0;
  logic [3:0]  cfg_gap = 4'd0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready;
  logic        tx_line;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_divisor(cfg_divisor), .cfg_len(cfg_len),
    .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .cfg_msb_first(cfg_msb_first),
    .cfg_gap(cfg_gap), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_line(tx_line), .busy(busy));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // send one word, record every cycle, compare with an expected waveform
  task automatic run_frame(input string req, input logic [7:0] w, input logic [1:0] len,
                           input logic [1:0] par, input logic [1:0] stp,
                           input logic msb, input logic [3:0] gap, input int div);
    int n, b, h, nb, ones, exp_busy, exp_total, busy_cnt, ready_low, bad, first_bad;
    logic exp_bits[0:15];
    logic rec[0:2047];
    logic p;
    n = 8 - int'(len);
    h = div / 2; if (h < 1) h = 1;
    b = 2 * h;
    exp_bits[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      exp_bits[1 + i] = msb ? w[n - 1 - i] : w[i];
      ones += int'(w[i]);
    end
    nb = 1 + n;
    if (par == 2'd1 || par == 2'd2) begin
      p = ones[0];
      if (par == 2'd2) p = ~p;
      exp_bits[nb] = p;
      nb++;
    end
    exp_busy  = nb * b + (stp == 2'd0 ? 2 : (stp == 2'd1 ? 3 : 4)) * h;
    exp_total = exp_busy + int'(gap) * b;

    @(negedge clk);
    cfg_divisor = 16'(div); cfg_len = len; cfg_parity = par; cfg_stop = stp;
    cfg_msb_first = msb; cfg_gap = gap; in_data = w; in_valid = 1'b1;
    @(posedge clk);
    busy_cnt = 0; ready_low = 0;
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      if (in_ready) begin
        in_valid = 1'b0;
        check({req, " line high when idle again"}, int'(tx_line), 1);
        break;
      end
      rec[i] = tx_line;
      if (busy) busy_cnt++;
      ready_low++;
      if (i == 0) begin
        // R9: scrambled inputs with in_valid kept high must not matter
        cfg_divisor = 16'd3; cfg_len = ~len; cfg_parity = 2'd2 - par[0];
        cfg_stop = ~stp; cfg_msb_first = ~msb; cfg_gap = ~gap; in_data = ~w;
      end
    end
    in_valid = 1'b0;
    bad = 0; first_bad = -1;
    for (int c = 0; c < ready_low && c < 2048; c++) begin
      logic e;
      e = (c < nb * b) ? exp_bits[c / b] : 1'b1;
      if (rec[c] !== e) begin
        bad++;
        if (first_bad < 0) first_bad = c;
      end
    end
    check({req, " waveform mismatching cycles (first at ", $sformatf("%0d", first_bad), ")"}, bad, 0);
    check({req, " busy cycles"}, busy_cnt, exp_busy);
    check({req, " not-ready cycles"}, ready_low, exp_total);
  endtask

  task automatic t_reset_state;  // R1
    repeat (3) @(negedge clk);
    check("R1 reset line", int'(tx_line), 1);
    check("R1 reset ready", int'(in_ready), 1);
    check("R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle line after release", int'(tx_line), 1);
  endtask

  task automatic t_basic;  // R2 R6 R7
    run_frame("R2 R6 8N1 lsb 0x41", 8'h41, 2'd0, 2'd0, 2'd0, 1'b0, 4'd0, 8);
    run_frame("R2 8N1 lsb 0xA5", 8'hA5, 2'd0, 2'd0, 2'd0, 1'b0, 4'd0, 8);
  endtask

  task automatic t_parity;  // R4
    run_frame("R4 even 0x41", 8'h41, 2'd0, 2'd1, 2'd0, 1'b0, 4'd0, 8);
    run_frame("R4 odd 0x41", 8'h41, 2'd0, 2'd2, 2'd0, 1'b0, 4'd0, 8);
    run_frame("R4 code3 none 0x7F", 8'h7F, 2'd0, 2'd3, 2'd0, 1'b0, 4'd0, 8);
  endtask

  task automatic t_msb;  // R6
    run_frame("R6 msb first 0x41", 8'h41, 2'd0, 2'd0, 2'd0, 1'b1, 4'd0, 8);
  endtask

  task automatic t_short;  // R3
    run_frame("R3 5 bits odd 0xE5 upper masked", 8'hE5, 2'd3, 2'd2, 2'd0, 1'b0, 4'd0, 8);
    run_frame("R3 6 bits msb even 0xF3", 8'hF3, 2'd2, 2'd1, 2'd0, 1'b1, 4'd0, 8);
    run_frame("R3 7 bits 0x80", 8'h80, 2'd1, 2'd0, 2'd0, 1'b0, 4'd0, 8);
  endtask

  task automatic t_stop;  // R5
    run_frame("R5 stop 1.5", 8'h3C, 2'd0, 2'd0, 2'd1, 1'b0, 4'd0, 8);
    run_frame("R5 stop 2", 8'h3C, 2'd0, 2'd0, 2'd2, 1'b0, 4'd0, 8);
    run_frame("R5 stop code3", 8'h3C, 2'd0, 2'd1, 2'd3, 1'b0, 4'd0, 8);
  endtask

  task automatic t_gap;  // R8 R9
    run_frame("R8 gap 3", 8'h55, 2'd0, 2'd0, 2'd0, 1'b0, 4'd3, 8);
    run_frame("R8 gap 15 stop 1.5", 8'hC3, 2'd0, 2'd2, 2'd1, 1'b0, 4'd15, 8);
  endtask

  task automatic t_divisor;  // R7
    run_frame("R7 divisor 9 odd", 8'h96, 2'd0, 2'd0, 2'd0, 1'b0, 4'd0, 9);
    run_frame("R7 divisor 12", 8'h96, 2'd0, 2'd1, 2'd1, 1'b1, 4'd1, 12);
    run_frame("R7 divisor 2", 8'h5A, 2'd0, 2'd0, 2'd0, 1'b0, 4'd0, 2);
  endtask

  task automatic t_reset_mid;  // R10
    @(negedge clk);
    cfg_divisor = 16'd8; cfg_len = 2'd0; cfg_parity = 2'd0; cfg_stop = 2'd2;
    cfg_gap = 4'd2; in_data = 8'h00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    check("R10 frame running before reset", int'(busy), 1);
    rst_n = 1'b0;
    #1;
    check("R10 line high on reset", int'(tx_line), 1);
    check("R10 busy low on reset", int'(busy), 0);
    check("R10 ready on reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check("R10 stays idle after release", int'(tx_line) + 2 * int'(in_ready), 3);
  endtask

  initial begin
    t_reset_state();
    t_basic();
    t_parity();
    t_msb();
    t_short();
    t_stop();
    t_gap();
    t_divisor();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule